// File: doc/BRIEF.md
# Multiframe-Locked SYSREF Strobe Generator

This block produces a periodic SYSREF timing strobe in the link-clock domain of a JESD204B subsystem. Its period equals one local multiframe: with F octets per frame, K frames per multiframe and four octets carried per link clock, one multiframe lasts F*K/4 link clocks. The same pulse train is meant to fan out to the data converter and to the receive link core, so that both align their multiframe counters to a common edge. Pulses keep running for as long as the block is enabled, including after the link has come up.

A single enable input gates the train. Changes to the enable are applied only at a multiframe boundary, and a disable never cuts a pulse short, so the output never carries a runt pulse. A separate one-cycle boundary strobe marks every multiframe boundary whether or not the SYSREF output is enabled. F and K are compile-time parameters; a combination whose product is not a multiple of four is rejected at elaboration.

Top module: `sysref_lmfc_gen`

## Requirements
- R1: `lmfc_o` is high for exactly one cycle every P = F*K/4 link clocks, independent of `en_i`; counting posedges after reset release from 1, it is high after edge n exactly when n is a positive multiple of P.
- R2: While `rst_i` is high at a clock edge, both outputs are low after that edge and the generator leaves reset disabled.
- R3: When enabled, `sysref_o` is high for H = max(1, floor(P/2)) cycles starting in the same cycle as `lmfc_o`, and low for the remaining P-H cycles of the period.
- R4: A rise of `en_i` takes effect only at the next multiframe boundary: the value of `en_i` sampled at edge n, where n is a multiple of P, decides whether the pulse of the period beginning after that edge is produced.
- R5: A fall of `en_i` never shortens a pulse: a pulse that has started always lasts H cycles, and a rise of `sysref_o` is always accompanied by `lmfc_o`.
- R6: While enabled, pulses repeat without gaps: every window of k*P consecutive cycles contains exactly k rising edges of `sysref_o`.
- R7: With the default parameters (F=1, K=32) the period is 8 link clocks and the pulse is 4 cycles wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Link clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | SYSREF enable, 1 = pulses on, 0 = off |
| sysref_o | output | 1 | SYSREF pulse train, registered |
| lmfc_o | output | 1 | One-cycle multiframe boundary strobe, registered |

## Verification
A wrong period count shows within one multiframe as an `lmfc_o` strobe at the wrong cycle, and in the same cycle as a misplaced `sysref_o` rise when enabled. A stale or wrongly latched enable state shows as a pulse that appears or disappears one period too early or late, or as a pulse shorter than H cycles, visible on the first boundary after the enable changes. The bench runs two small configurations side by side, one with an even period and one with an odd period, and predicts both outputs every cycle from the edge count since reset.

// File: rtl/sref_pkg.sv
package sref_pkg;

  // Link clocks per local multiframe when four octets move per clock.
  function automatic int unsigned mf_clocks(input int unsigned f_oct, input int unsigned k_frm);
    return (f_oct * k_frm) / 4;
  endfunction

  // High time of the strobe: half the period, never below one cycle.
  function automatic int unsigned hi_clocks(input int unsigned period);
    return (period / 2 < 1) ? 1 : period / 2;
  endfunction

  // Counter width able to hold 0..period-1, at least one bit.
  function automatic int unsigned cnt_bits(input int unsigned period);
    return (period > 1) ? $clog2(period) : 1;
  endfunction

endpackage

// File: rtl/sref_mf_counter.sv
module sref_mf_counter #(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned CW    = sref_pkg::cnt_bits(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assign wrap    = (cnt_q == LAST);
  assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nxt;
  end

  // R1: phase never leaves the multiframe range
  a_r1_phase_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST);

endmodule

// File: rtl/sref_pulse_gate.sv
module sref_pulse_gate #(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned CW    = sref_pkg::cnt_bits(PERIOD),
  localparam int unsigned HI    = sref_pkg::hi_clocks(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic          wrap,
  input  logic [CW-1:0] cnt_nxt,
  output logic          active_q,
  output logic          pulse_q
);

  localparam logic [CW:0] HI_W = (CW+1)'(HI);

  logic active_nxt;

  // The enable is only latched on a boundary, so a period is all-or-nothing.
  assign active_nxt = wrap ? en_i : active_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      active_q <= active_nxt;
      pulse_q  <= active_nxt && ({1'b0, cnt_nxt} < HI_W);
    end
  end

  // R4: the latched enable changes only right after a boundary
  a_r4_enable_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_q != $past(active_q)) |-> $past(wrap));

endmodule

// File: rtl/sysref_lmfc_gen.sv
module sysref_lmfc_gen #(
  parameter int unsigned FRAME_OCTETS = 1,
  parameter int unsigned MF_FRAMES    = 32,
  localparam int unsigned PERIOD = sref_pkg::mf_clocks(FRAME_OCTETS, MF_FRAMES),
  localparam int unsigned HI     = sref_pkg::hi_clocks(PERIOD),
  localparam int unsigned CW     = sref_pkg::cnt_bits(PERIOD)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic sysref_o,
  output logic lmfc_o
);

  generate
    if (((FRAME_OCTETS * MF_FRAMES) % 4 != 0) || (PERIOD < 1)) begin : g_bad_cfg
      initial $error("frame octets times frames per multiframe must be a positive multiple of 4");
    end
  endgenerate

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          mf_wrap;
  logic          gate_active;
  logic          lmfc_q;

  sref_mf_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (mf_wrap)
  );

  sref_pulse_gate #(.PERIOD(PERIOD)) u_gate (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .wrap     (mf_wrap),
    .cnt_nxt  (cnt_nxt),
    .active_q (gate_active),
    .pulse_q  (sysref_o)
  );

  // Boundary strobe registered so it lines up with the registered pulse.
  always_ff @(posedge clk_i) begin
    if (rst_i) lmfc_q <= 1'b0;
    else       lmfc_q <= mf_wrap;
  end
  assign lmfc_o = lmfc_q;

  // R5: every pulse starts on a multiframe boundary
  a_r5_rise_on_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sysref_o) |-> lmfc_o);

  // R2: nothing leaves reset enabled
  a_r2_quiet_after_reset: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!sysref_o && !lmfc_o && !gate_active));

  generate
    if (PERIOD > 1) begin : g_multi
      // R1: boundary strobe lasts one cycle
      a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        lmfc_o |=> !lmfc_o);
      // R3: a pulse ends only once its full width has elapsed
      a_r3_full_width: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sysref_o) |-> (cnt_q == CW'(HI)));
    end
  endgenerate

endmodule

// File: tb/sim_sysref_lmfc_gen.sv
`timescale 1ns/1ps
module sim_sysref_lmfc_gen;

  // Expected shapes worked out from F and K directly.
  localparam int F0 = 1, K0 = 32;
  localparam int F1 = 2, K1 = 10;
  localparam int P0 = F0 * K0 / 4;
  localparam int P1 = F1 * K1 / 4;
  localparam int H0 = (P0 / 2 > 0) ? P0 / 2 : 1;
  localparam int H1 = (P1 / 2 > 0) ? P1 / 2 : 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic sys0, lm0, sys1, lm1;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  logic act0 = 1'b0, act1 = 1'b0;
  bit   live = 1'b0;
  string tag = "R2";

  always #2.5 clk = ~clk;

  sysref_lmfc_gen #(.FRAME_OCTETS(F0), .MF_FRAMES(K0)) u0 (
    .clk_i(clk), .rst_i(rst), .en_i(en), .sysref_o(sys0), .lmfc_o(lm0));
  sysref_lmfc_gen #(.FRAME_OCTETS(F1), .MF_FRAMES(K1)) u1 (
    .clk_i(clk), .rst_i(rst), .en_i(en), .sysref_o(sys1), .lmfc_o(lm1));

  // Reference model: edge count since reset release.
  always @(posedge clk) begin
    if (rst) begin
      n = 0; act0 = 1'b0; act1 = 1'b0;
    end else begin
      n = n + 1;
      if (n % P0 == 0) act0 = en;
      if (n % P1 == 0) act1 = en;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at n=%0d: actual=%b expected=%b", req, what, n, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check(rst ? "R2" : "R1", "lmfc u0", lm0, (n > 0) && (n % P0 == 0));
      check(rst ? "R2" : "R1", "lmfc u1", lm1, (n > 0) && (n % P1 == 0));
      check(rst ? "R2" : tag, "sysref u0", sys0, act0 && (n % P0 < H0));
      check(rst ? "R2" : tag, "sysref u1", sys1, act1 && (n % P1 < H1));
    end
  end

  task automatic cyc(input int c);
    repeat (c) @(negedge clk);
  endtask

  int gap;
  int rises0, rises1;
  logic p0, p1;

  initial begin
    cyc(1); live = 1'b1;
    cyc(3);
    @(negedge clk) rst = 1'b0;
    tag = "R1";
    cyc(13);                       // disabled: boundary strobes only
    tag = "R4"; en = 1'b1;         // mid-period enable
    cyc(30);
    tag = "R5"; en = 1'b0;         // disable during a pulse
    cyc(19);
    en = 1'b1; cyc(2); en = 1'b0;  // short blip off a boundary
    cyc(21);
    tag = "R3"; en = 1'b1;
    cyc(3);
    // R6: count rises over a whole number of periods
    rises0 = 0; rises1 = 0; p0 = sys0; p1 = sys1;
    for (int i = 0; i < P0 * P1 * 2; i++) begin
      @(negedge clk);
      if (sys0 && !p0) rises0++;
      if (sys1 && !p1) rises1++;
      p0 = sys0; p1 = sys1;
    end
    checks++;
    if (rises0 != 2 * P1) begin fails++;
      $display("FAIL R6 rises u0: actual=%0d expected=%0d", rises0, 2 * P1); end
    checks++;
    if (rises1 != 2 * P0) begin fails++;
      $display("FAIL R6 rises u1: actual=%0d expected=%0d", rises1, 2 * P0); end
    // R7: default configuration spacing of boundary strobes is 8
    while (!lm0) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!lm0 && gap < 100);
    checks++;
    if (gap != 8) begin fails++;
      $display("FAIL R7 lmfc spacing: actual=%0d expected=%0d", gap, 8); end
    // R7: default pulse width 4
    while (!sys0) @(negedge clk);
    gap = 0;
    while (sys0 && gap < 100) begin @(negedge clk); gap++; end
    checks++;
    if (gap != 4) begin fails++;
      $display("FAIL R7 pulse width: actual=%0d expected=%0d", gap, 4); end
    // R2: re-enter reset while running
    tag = "R2"; rst = 1'b1;
    cyc(4);
    rst = 1'b0; tag = "R4";
    cyc(20);
    live = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule